// File: doc/BRIEF.md
# UART Interrupt Priority Controller

This block collects every interrupt condition of a UART channel. It masks each condition with an enable register and reports the most urgent unmasked one as a six-bit priority code. It also raises a single interrupt line while any unmasked condition is pending. The FIFOs, shifters, flow-control engine and host bus sit outside the block. They deliver FIFO levels, status flags, detection pulses and one-cycle register-access strobes. The block answers with the code that a read of its status register would return, and with the interrupt line.

Each condition has its own life cycle. Some conditions simply follow a level: line errors and the receive FIFO fill level. Others are latched on an event and released by a specific register access or by a later event. The receive time-out uses a character timer that is built into the block. The timer counts bit-rate ticks while data waits in the receive FIFO. The three flow-control related enables only take effect when an enhanced-mode input is high.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the enable register is 0, `irq` is 0 and `isr_code` is 0x01 (nothing pending).
- R2: Enable bit 5 (Xoff/special), bit 6 (RTS edge) and bit 7 (CTS edge) have no effect unless `enh_en` is 1. The other bits are bit 0 for receive data and time-out, bit 1 for transmit, bit 2 for line status, bit 3 for modem and bit 4 for GPIO.
- R3: The reported code comes from the highest enabled pending source. In falling priority, the sources and codes are: line status 0x06, time-out 0x0C, receive ready 0x04, transmit ready 0x02, modem 0x00, GPIO 0x30, Xoff/special 0x10, CTS/RTS 0x20.
- R4: Line status is pending while any of `lsr_flags` bits 1, 2, 3, 4 or 7 is 1. Bits 0, 5 and 6 are ignored. The condition clears when those bits fall.
- R5: Receive ready is pending while `rx_level` >= `rx_trig`.
- R6: The time-out latches once `4*C+12` ticks have been counted with a non-empty receive FIFO. C is the character length in bits: 7 + `cfg_wlen` + `cfg_par` + `cfg_stop2`. The count restarts on `rx_push` or `rhr_rd` and is held at zero while the FIFO is empty. The time-out clears on `rhr_rd`.
- R7: Transmit ready latches when `tx_level <= tx_trig` becomes true. It clears on `thr_wr`, or on `isr_rd` when the code being read is 0x02. A status read that returns another code leaves it pending.
- R8: The modem source latches on any `msr_chg` bit and clears on `msr_rd`.
- R9: A low-to-high edge of `cts_in` while `auto_cts` is 1 latches the CTS source. A low-to-high edge of `rts_lvl` while `auto_rts` is 1 latches the RTS source. Both clear on `msr_rd`, and edges seen while the auto mode is off are ignored.
- R10: Any change of `gpio_in` latches the GPIO source, and `io_rd` clears it.
- R11: Xoff clears only on `xon_det`. The special-character source clears on `isr_rd` returning 0x10. Both share code 0x10.
- R12: `irq` is 1 exactly when some enabled source is pending. Disabled sources never alter `isr_code`.
- R13: When a latch sees its set event and its clear strobe in the same cycle, it stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ier_we | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| enh_en | input | 1 | Enhanced mode, unlocks enable bits 5-7 |
| isr_rd | input | 1 | Status register read strobe |
| isr_code | output | 6 | Highest pending priority code |
| irq | output | 1 | Interrupt request, active high |
| lsr_flags | input | 8 | Line status flags |
| rx_level | input | FIFO_AW | Receive FIFO fill level |
| rx_trig | input | FIFO_AW | Receive trigger level |
| rx_push | input | 1 | Character written into receive FIFO |
| rhr_rd | input | 1 | Receive holding register read strobe |
| baud_tick | input | 1 | One pulse per bit time |
| cfg_wlen | input | 2 | Word length minus five |
| cfg_par | input | 1 | Parity bit present |
| cfg_stop2 | input | 1 | Second stop bit present |
| tx_level | input | FIFO_AW | Transmit FIFO fill level |
| tx_trig | input | FIFO_AW | Transmit trigger level |
| thr_wr | input | 1 | Transmit holding register write strobe |
| msr_chg | input | 4 | Modem line change flags |
| msr_rd | input | 1 | Modem status read strobe |
| auto_cts | input | 1 | Automatic CTS flow control on |
| cts_in | input | 1 | CTS line level |
| auto_rts | input | 1 | Automatic RTS flow control on |
| rts_lvl | input | 1 | RTS output level |
| gpio_in | input | GPIO_W | GPIO input levels |
| io_rd | input | 1 | IO state read strobe |
| xoff_det | input | 1 | Xoff character received |
| xon_det | input | 1 | Xon character received |
| spec_det | input | 1 | Special character received |

## Verification
Two functions can fall in the same cycle: the rising transmit-ready condition, and a status read that reports code 0x02 and therefore clears that source. The bench provokes this while the transmit source is still pending. It first pushes the transmit level above the trigger. Then, in one cycle, it drops the level below the trigger and pulses the status read. The result passes only if code 0x02 is still reported afterwards. A related case is a status read that returns a higher code while transmit ready is queued. That read must leave the queued source untouched.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   localparam int NUM_SRC = 8;
   localparam int SRC_LS   = 0;
   localparam int SRC_TO   = 1;
   localparam int SRC_RX   = 2;
   localparam int SRC_TX   = 3;
   localparam int SRC_MS   = 4;
   localparam int SRC_GPIO = 5;
   localparam int SRC_XS   = 6;
   localparam int SRC_FC   = 7;
   localparam logic [5:0] CODE_NONE = 6'h01;
   localparam logic [7:0] LS_MASK   = 8'h9E;

   function automatic logic [5:0] src_code(input logic [2:0] idx);
      case (idx)
         3'd0:    return 6'h06;
         3'd1:    return 6'h0C;
         3'd2:    return 6'h04;
         3'd3:    return 6'h02;
         3'd4:    return 6'h00;
         3'd5:    return 6'h30;
         3'd6:    return 6'h10;
         default: return 6'h20;
      endcase
   endfunction
endpackage

// File: rtl/uart_char_timer.sv
module uart_char_timer #(
   parameter int CHAR_GAPS  = 4,
   parameter int EXTRA_BITS = 12
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       rx_nonempty,
   input  logic       rx_push,
   input  logic       rhr_rd,
   input  logic [1:0] wlen,
   input  logic       par,
   input  logic       stop2,
   output logic       to_pend
);
   localparam int MAX_LIM = CHAR_GAPS * 12 + EXTRA_BITS;
   localparam int CNT_W   = $clog2(MAX_LIM + 1);

   logic [3:0]       char_bits;
   logic [CNT_W-1:0] limit;
   logic [CNT_W-1:0] cnt;
   logic             restart;

   always_comb begin
      char_bits = 4'd7 + {2'b00, wlen} + {3'b000, par} + {3'b000, stop2};
      limit     = CNT_W'(CHAR_GAPS) * CNT_W'(char_bits) + CNT_W'(EXTRA_BITS);
      restart   = !rx_nonempty || rx_push || rhr_rd;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '0;
         to_pend <= 1'b0;
      end else begin
         if (rhr_rd)
            to_pend <= 1'b0;
         else if (!restart && tick && cnt == limit - CNT_W'(1))
            to_pend <= 1'b1;
         if (restart)
            cnt <= '0;
         else if (tick && cnt < limit)
            cnt <= cnt + CNT_W'(1);
      end
   end

   // R6
   to_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rhr_rd |=> !to_pend);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio #(
   parameter int N = 8
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant,
   output logic         any
);
   always_comb begin
      grant = req & (~req + N'(1));
      any   = |req;
   end
endmodule

// File: rtl/uart_irq_sources.sv
module uart_irq_sources
   import uart_irq_pkg::*;
#(
   parameter int FIFO_AW      = 7,
   parameter int GPIO_W       = 4,
   parameter bit TX_TRIG_MODE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [7:0]         lsr_flags,
   input  logic [FIFO_AW-1:0] rx_level,
   input  logic [FIFO_AW-1:0] rx_trig,
   input  logic [FIFO_AW-1:0] tx_level,
   input  logic [FIFO_AW-1:0] tx_trig,
   input  logic               thr_wr,
   input  logic               isr_rd_tx,
   input  logic               isr_rd_xs,
   input  logic [3:0]         msr_chg,
   input  logic               msr_rd,
   input  logic               auto_cts,
   input  logic               cts_in,
   input  logic               auto_rts,
   input  logic               rts_lvl,
   input  logic [GPIO_W-1:0]  gpio_in,
   input  logic               io_rd,
   input  logic               xoff_det,
   input  logic               xon_det,
   input  logic               spec_det,
   output logic               ls_p,
   output logic               rx_p,
   output logic               tx_p,
   output logic               ms_p,
   output logic               gpio_p,
   output logic               xoff_p,
   output logic               spec_p,
   output logic               cts_p,
   output logic               rts_p
);
   logic              tx_cond, tx_prev, cts_prev, rts_prev;
   logic [GPIO_W-1:0] gpio_prev;
   logic              tx_set, cts_set, rts_set, gpio_set;

   generate
      if (TX_TRIG_MODE) begin : g_tx_trig
         assign tx_cond = (tx_level <= tx_trig);
      end else begin : g_tx_empty
         assign tx_cond = (tx_level == '0);
      end
   endgenerate

   always_comb begin
      ls_p     = |(lsr_flags & LS_MASK);
      rx_p     = (rx_level >= rx_trig);
      tx_set   = tx_cond && !tx_prev;
      cts_set  = auto_cts && cts_in && !cts_prev;
      rts_set  = auto_rts && rts_lvl && !rts_prev;
      gpio_set = |(gpio_in ^ gpio_prev);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_prev   <= 1'b0;
         cts_prev  <= 1'b0;
         rts_prev  <= 1'b0;
         gpio_prev <= '0;
         tx_p      <= 1'b0;
         ms_p      <= 1'b0;
         gpio_p    <= 1'b0;
         xoff_p    <= 1'b0;
         spec_p    <= 1'b0;
         cts_p     <= 1'b0;
         rts_p     <= 1'b0;
      end else begin
         tx_prev   <= tx_cond;
         cts_prev  <= cts_in;
         rts_prev  <= rts_lvl;
         gpio_prev <= gpio_in;
         if (tx_set) tx_p <= 1'b1;
         else if (thr_wr || isr_rd_tx) tx_p <= 1'b0;
         if (|msr_chg) ms_p <= 1'b1;
         else if (msr_rd) ms_p <= 1'b0;
         if (cts_set) cts_p <= 1'b1;
         else if (msr_rd) cts_p <= 1'b0;
         if (rts_set) rts_p <= 1'b1;
         else if (msr_rd) rts_p <= 1'b0;
         if (gpio_set) gpio_p <= 1'b1;
         else if (io_rd) gpio_p <= 1'b0;
         if (xoff_det) xoff_p <= 1'b1;
         else if (xon_det) xoff_p <= 1'b0;
         if (spec_det) spec_p <= 1'b1;
         else if (isr_rd_xs) spec_p <= 1'b0;
      end
   end

   // R13
   tx_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_cond && !tx_prev) |=> tx_p);
   // R11
   xoff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xoff_p && !xon_det) |=> xoff_p);
   // R8
   ms_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msr_rd && msr_chg == 4'b0000) |=> !ms_p);
   // R10
   gpio_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && gpio_in == gpio_prev) |=> !gpio_p);
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
   import uart_irq_pkg::*;
#(
   parameter int FIFO_AW      = 7,
   parameter int GPIO_W       = 4,
   parameter bit TX_TRIG_MODE = 1'b1,
   parameter int CHAR_GAPS    = 4,
   parameter int EXTRA_BITS   = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ier_we,
   input  logic [7:0]         ier_wdata,
   input  logic               enh_en,
   input  logic               isr_rd,
   output logic [5:0]         isr_code,
   output logic               irq,
   input  logic [7:0]         lsr_flags,
   input  logic [FIFO_AW-1:0] rx_level,
   input  logic [FIFO_AW-1:0] rx_trig,
   input  logic               rx_push,
   input  logic               rhr_rd,
   input  logic               baud_tick,
   input  logic [1:0]         cfg_wlen,
   input  logic               cfg_par,
   input  logic               cfg_stop2,
   input  logic [FIFO_AW-1:0] tx_level,
   input  logic [FIFO_AW-1:0] tx_trig,
   input  logic               thr_wr,
   input  logic [3:0]         msr_chg,
   input  logic               msr_rd,
   input  logic               auto_cts,
   input  logic               cts_in,
   input  logic               auto_rts,
   input  logic               rts_lvl,
   input  logic [GPIO_W-1:0]  gpio_in,
   input  logic               io_rd,
   input  logic               xoff_det,
   input  logic               xon_det,
   input  logic               spec_det
);
   generate
      if (FIFO_AW < 2) begin : g_bad_aw
         $error("FIFO_AW must be at least 2");
      end
      if (GPIO_W < 1) begin : g_bad_gpio
         $error("GPIO_W must be at least 1");
      end
      if (CHAR_GAPS < 1) begin : g_bad_gaps
         $error("CHAR_GAPS must be at least 1");
      end
   endgenerate

   logic [7:0]         ier_q, eff_ier;
   logic [NUM_SRC-1:0] en_pend, grant;
   logic               any_p;
   logic ls_p, rx_p, tx_p, ms_p, gpio_p, xoff_p, spec_p, cts_p, rts_p, to_p;

   always_ff @(posedge clk) begin
      if (!rst_n)      ier_q <= 8'h00;
      else if (ier_we) ier_q <= ier_wdata;
   end

   uart_char_timer #(.CHAR_GAPS(CHAR_GAPS), .EXTRA_BITS(EXTRA_BITS)) u_timer (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rx_nonempty(rx_level != '0),
      .rx_push(rx_push), .rhr_rd(rhr_rd), .wlen(cfg_wlen), .par(cfg_par),
      .stop2(cfg_stop2), .to_pend(to_p));

   uart_irq_sources #(.FIFO_AW(FIFO_AW), .GPIO_W(GPIO_W), .TX_TRIG_MODE(TX_TRIG_MODE)) u_src (
      .clk(clk), .rst_n(rst_n), .lsr_flags(lsr_flags), .rx_level(rx_level),
      .rx_trig(rx_trig), .tx_level(tx_level), .tx_trig(tx_trig), .thr_wr(thr_wr),
      .isr_rd_tx(isr_rd && grant[SRC_TX]), .isr_rd_xs(isr_rd && grant[SRC_XS]),
      .msr_chg(msr_chg), .msr_rd(msr_rd), .auto_cts(auto_cts), .cts_in(cts_in),
      .auto_rts(auto_rts), .rts_lvl(rts_lvl), .gpio_in(gpio_in), .io_rd(io_rd),
      .xoff_det(xoff_det), .xon_det(xon_det), .spec_det(spec_det),
      .ls_p(ls_p), .rx_p(rx_p), .tx_p(tx_p), .ms_p(ms_p), .gpio_p(gpio_p),
      .xoff_p(xoff_p), .spec_p(spec_p), .cts_p(cts_p), .rts_p(rts_p));

   always_comb begin
      eff_ier           = {ier_q[7:5] & {3{enh_en}}, ier_q[4:0]};
      en_pend[SRC_LS]   = ls_p && eff_ier[2];
      en_pend[SRC_TO]   = to_p && eff_ier[0];
      en_pend[SRC_RX]   = rx_p && eff_ier[0];
      en_pend[SRC_TX]   = tx_p && eff_ier[1];
      en_pend[SRC_MS]   = ms_p && eff_ier[3];
      en_pend[SRC_GPIO] = gpio_p && eff_ier[4];
      en_pend[SRC_XS]   = (xoff_p || spec_p) && eff_ier[5];
      en_pend[SRC_FC]   = (rts_p && eff_ier[6]) || (cts_p && eff_ier[7]);
   end

   uart_irq_prio #(.N(NUM_SRC)) u_prio (.req(en_pend), .grant(grant), .any(any_p));

   always_comb begin
      isr_code = CODE_NONE;
      for (int i = 0; i < NUM_SRC; i++)
         if (grant[i]) isr_code = src_code(3'(i));
      irq = any_p;
   end

   // R12
   irq_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (isr_code != CODE_NONE));
   // R3
   ls_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eff_ier[2] && |(lsr_flags & LS_MASK)) |-> isr_code == 6'h06);
endmodule

// File: tb/uart_irq_ctrl_tb.sv
`timescale 1ns/1ps
module uart_irq_ctrl_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ier_we = 0, enh_en = 0, isr_rd = 0, rx_push = 0, rhr_rd = 0, baud_tick = 1;
   logic [7:0] ier_wdata = 0, lsr_flags = 0;
   logic [6:0] rx_level = 0, rx_trig = 7'd4, tx_level = 0, tx_trig = 7'd4;
   logic [1:0] cfg_wlen = 2'd3;
   logic cfg_par = 0, cfg_stop2 = 0, thr_wr = 0, msr_rd = 0, io_rd = 0;
   logic [3:0] msr_chg = 0, gpio_in = 0;
   logic auto_cts = 0, cts_in = 0, auto_rts = 0, rts_lvl = 0;
   logic xoff_det = 0, xon_det = 0, spec_det = 0;
   logic [5:0] isr_code;
   logic irq;
   int errors = 0, checks = 0;

   always #4 clk = ~clk;

   uart_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .ier_we(ier_we), .ier_wdata(ier_wdata), .enh_en(enh_en),
      .isr_rd(isr_rd), .isr_code(isr_code), .irq(irq), .lsr_flags(lsr_flags),
      .rx_level(rx_level), .rx_trig(rx_trig), .rx_push(rx_push), .rhr_rd(rhr_rd),
      .baud_tick(baud_tick), .cfg_wlen(cfg_wlen), .cfg_par(cfg_par), .cfg_stop2(cfg_stop2),
      .tx_level(tx_level), .tx_trig(tx_trig), .thr_wr(thr_wr), .msr_chg(msr_chg),
      .msr_rd(msr_rd), .auto_cts(auto_cts), .cts_in(cts_in), .auto_rts(auto_rts),
      .rts_lvl(rts_lvl), .gpio_in(gpio_in), .io_rd(io_rd), .xoff_det(xoff_det),
      .xon_det(xon_det), .spec_det(spec_det));

   // {lsr_flags, rx_level, expected code}, enables 0x0F, rx_trig 4
   localparam logic [20:0] VEC [11] = '{
      {8'h00, 7'd0, 6'h01}, {8'h01, 7'd0, 6'h01}, {8'h20, 7'd0, 6'h01},
      {8'h02, 7'd0, 6'h06}, {8'h80, 7'd0, 6'h06}, {8'h00, 7'd4, 6'h04},
      {8'h00, 7'd3, 6'h01}, {8'h00, 7'd9, 6'h04}, {8'h10, 7'd9, 6'h06},
      {8'h40, 7'd3, 6'h01}, {8'h08, 7'd5, 6'h06}};

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_ier(input logic [7:0] v);
      ier_we = 1; ier_wdata = v; step(1); ier_we = 0;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      step(3);
      rst_n = 1;
      step(2);
      chk("R1 code", isr_code, 6'h01);
      chk("R1 irq", irq, 0);
      thr_wr = 1; step(1); thr_wr = 0;
      wr_ier(8'h0F);
      for (int i = 0; i < 11; i++) begin
         lsr_flags = VEC[i][20:13];
         rx_level  = VEC[i][12:6];
         step(1);
         chk("R3 R4 R5 table", isr_code, VEC[i][5:0]);
      end
      lsr_flags = 0; rx_level = 0; #1;

      // R12 disabled source
      wr_ier(8'h00);
      lsr_flags = 8'h02; #1;
      chk("R12 disabled code", isr_code, 6'h01);
      chk("R12 disabled irq", irq, 0);
      lsr_flags = 0;
      wr_ier(8'hFF);

      // R2 and R11
      xoff_det = 1; step(1); xoff_det = 0;
      chk("R2 locked xoff", isr_code, 6'h01);
      enh_en = 1; #1;
      chk("R2 unlocked xoff", isr_code, 6'h10);
      chk("R12 irq on", irq, 1);
      isr_rd = 1; step(1); isr_rd = 0;
      chk("R11 xoff kept by status read", isr_code, 6'h10);
      xon_det = 1; step(1); xon_det = 0;
      chk("R11 xon clears", isr_code, 6'h01);
      spec_det = 1; step(1); spec_det = 0;
      chk("R11 special set", isr_code, 6'h10);
      isr_rd = 1; step(1); isr_rd = 0;
      chk("R11 special cleared", isr_code, 6'h01);

      // R9
      cts_in = 1; step(2);
      chk("R9 edge ignored without auto", isr_code, 6'h01);
      cts_in = 0; step(1);
      auto_cts = 1; cts_in = 1; step(1);
      chk("R9 cts edge", isr_code, 6'h20);
      msr_rd = 1; step(1); msr_rd = 0;
      chk("R9 cts clear", isr_code, 6'h01);
      auto_rts = 1; rts_lvl = 1; step(1);
      chk("R9 rts edge", isr_code, 6'h20);
      msr_rd = 1; step(1); msr_rd = 0;
      chk("R9 rts clear", isr_code, 6'h01);

      // R8 R10
      msr_chg = 4'b0100; step(1); msr_chg = 0;
      chk("R8 modem set", isr_code, 6'h00);
      gpio_in = 4'b0010; step(1);
      chk("R3 modem over gpio", isr_code, 6'h00);
      msr_rd = 1; step(1); msr_rd = 0;
      chk("R10 gpio queued", isr_code, 6'h30);
      io_rd = 1; step(1); io_rd = 0;
      chk("R10 gpio clear", isr_code, 6'h01);

      // R7 R13
      tx_level = 7'd10; step(1);
      chk("R7 above trigger", isr_code, 6'h01);
      tx_level = 7'd2; step(1);
      chk("R7 tx set", isr_code, 6'h02);
      msr_chg = 4'b0001; step(1); msr_chg = 0;
      chk("R3 tx over modem", isr_code, 6'h02);
      isr_rd = 1; step(1); isr_rd = 0;
      chk("R7 status read clears tx", isr_code, 6'h00);
      msr_rd = 1; step(1); msr_rd = 0;
      tx_level = 7'd10; step(1); tx_level = 7'd2; step(1);
      lsr_flags = 8'h02; #1;
      chk("R4 line status over tx", isr_code, 6'h06);
      isr_rd = 1; step(1); isr_rd = 0;
      lsr_flags = 0; #1;
      chk("R7 tx kept after other code read", isr_code, 6'h02);
      tx_level = 7'd10; step(1);
      tx_level = 7'd2; isr_rd = 1; step(1); isr_rd = 0;
      chk("R13 set wins over clear", isr_code, 6'h02);
      thr_wr = 1; step(1); thr_wr = 0;
      chk("R7 thr write clears", isr_code, 6'h01);

      // R6 time-out, C=10 -> 52 ticks
      rx_level = 7'd1;
      rx_push = 1; step(1); rx_push = 0;
      step(51);
      chk("R6 before limit", isr_code, 6'h01);
      step(1);
      chk("R6 fires", isr_code, 6'h0C);
      rhr_rd = 1; step(1); rhr_rd = 0;
      chk("R6 rhr clears", isr_code, 6'h01);
      step(30);
      rx_push = 1; step(1); rx_push = 0;
      step(51);
      chk("R6 restart on push", isr_code, 6'h01);
      step(1);
      chk("R6 fires after restart", isr_code, 6'h0C);
      rhr_rd = 1; rx_level = 0; step(1); rhr_rd = 0;
      step(100);
      chk("R6 held while empty", isr_code, 6'h01);
      // C = 7+0+1+1 = 9 -> 48 ticks
      cfg_wlen = 2'd0; cfg_par = 1; cfg_stop2 = 1; rx_level = 7'd1;
      rx_push = 1; step(1); rx_push = 0;
      step(47);
      chk("R6 short char before limit", isr_code, 6'h01);
      step(1);
      chk("R6 short char fires", isr_code, 6'h0C);
      rhr_rd = 1; step(1); rhr_rd = 0;
      finish_run();
   end
endmodule